// File: doc/BRIEF.md
# Serial Configuration Register Slave (3-wire / 4-wire)

This block lets an external host reach a bank of 128 configuration registers, each 16 bits wide, through a synchronous serial port. The host pulls the active-low frame enable low, clocks in an 8-bit command and then moves 16 data bits. The command's top bit gives the direction and its low seven bits give the register address. Writes land in the bank. Reads are shifted back to the host. All register contents are presented in parallel on a flat output bus for the surrounding logic.

Register 0 is the control word. Its bit 1 selects 4-wire operation. In 4-wire mode, read data leaves on the bidirectional data pin and also on a dedicated data-out pin. In 3-wire mode the dedicated pin is never enabled. Bit 0 of register 0 is a soft reset: writing it as 1 returns the whole bank to zero, and the bit clears itself. The bank is clocked by the serial clock itself. A frame that stops before its last data bit leaves no trace in the bank.

Top module: `spi_rb_slave`

## Requirements
- R1: A frame begins when `frame_n` falls. Its first 8 bits are the command, MSB first. Command bit 7 = 1 means read and 0 means write. Command bits 6..0 are the register address, MSB first. The 16 data bits follow, MSB first.
- R2: Input bits are sampled on rising `sclk` edges and output bits change on falling edges. In a read, data bit 15 appears on the falling edge right after the 8th rising edge. Each later falling edge presents the next lower bit, so bit 0 appears after the 23rd rising edge.
- R3: A write updates the addressed register on the 24th rising edge of the frame. Reading that register afterwards returns the last value written. This holds at every address, including address 127.
- R4: A write frame that ends after fewer than 24 bits leaves every register unchanged.
- R5: In 3-wire mode (register 0 bit 1 = 0), read data is driven on `sdio_o` with `sdio_oe` = 1, and `sdo_oe` stays 0 for the whole frame.
- R6: In 4-wire mode (register 0 bit 1 = 1), `sdo_o` carries the same read data as `sdio_o` during the data phase, and both enables are 1.
- R7: After the last data bit of a read, the enabled outputs drive 0 from the falling edge after the 24th rising edge until `frame_n` rises. Both enables then go to 0.
- R8: No output is enabled while `frame_n` is high, during the command phase, or at any time in a write frame.
- R9: Writing a word with bit 0 set to address 0 clears all 128 registers to zero. This includes the mode bit, so the port returns to 3-wire, and register 0 reads back as 0.
- R10: While `rst_n` is low, every register is zero, the port is in 3-wire mode, and no output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low hard reset of the bank |
| sclk | input | 1 | Serial clock from the host |
| frame_n | input | 1 | Active-low frame enable |
| sdio_i | input | 1 | Bidirectional data pin, input side |
| sdio_o | output | 1 | Bidirectional data pin, output value |
| sdio_oe | output | 1 | Bidirectional data pin, output enable |
| sdo_o | output | 1 | Dedicated data-out pin value |
| sdo_oe | output | 1 | Dedicated data-out pin enable |
| regs_flat | output | 2048 | All registers, register n at bits [16n+15:16n] |

## Verification
Two functions meet on the same rising edge: the commit of a write to register 0 and the soft reset. A write of 0x0003 asks for 4-wire mode and a reset at once. The bench sends it after other registers have been loaded. It judges the outcome by reading registers back and by watching `sdo_oe` on the next read, which must stay 0. A second collision occurs in the tail of a read, where the last falling edge must drive 0 while the enable is still held and before `frame_n` rises. The bench samples that window and the moment just after `frame_n` rises.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;

  // total bits in one frame
  function automatic int frame_len(input int cmd_bits, input int data_bits);
    return cmd_bits + data_bits;
  endfunction

  // bit offset of register idx in the flat bus
  function automatic int reg_base(input int idx, input int data_bits);
    return idx * data_bits;
  endfunction

endpackage

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7,
  localparam int FRAME_BITS = frame_len(CMD_W, DATA_W),
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic              sclk,
  input  logic              frame_n,
  input  logic              sdi,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [ADDR_W-1:0] addr,
  output logic              is_read,
  output logic              wr_fire,
  output logic [DATA_W-1:0] wr_data
);

  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] dat_q;

  always_ff @(posedge sclk or posedge frame_n) begin
    if (frame_n) begin
      bit_cnt <= '0;
      cmd_q   <= '0;
      dat_q   <= '0;
    end else if (bit_cnt < CNT_W'(FRAME_BITS)) begin
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt < CNT_W'(CMD_W)) cmd_q <= {cmd_q[CMD_W-2:0], sdi};
      else                         dat_q <= {dat_q[DATA_W-2:0], sdi};
    end
  end

  assign addr    = cmd_q[ADDR_W-1:0];
  assign is_read = (cmd_q[CMD_W-1] == DIR_READ);
  // the last data bit is still on the pin at the commit edge
  assign wr_data = {dat_q[DATA_W-2:0], sdi};
  assign wr_fire = !frame_n && (bit_cnt == CNT_W'(FRAME_BITS - 1)) && !is_read;

endmodule

// File: rtl/spi_rb_bank.sv
module spi_rb_bank
  import spi_rb_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 7,
  parameter int CTRL_ADDR = 0,
  parameter int SRST_BIT  = 0
) (
  input  logic                       sclk,
  input  logic                       rst_n,
  input  logic                       wr_fire,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       soft_rst,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  assign soft_rst = wr_fire && (wr_addr == ADDR_W'(CTRL_ADDR)) && wr_data[SRST_BIT];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)
        regs_flat[reg_base(g, DATA_W) +: DATA_W] <= '0;
      else if (soft_rst)
        regs_flat[reg_base(g, DATA_W) +: DATA_W] <= '0;
      else if (wr_fire && (wr_addr == ADDR_W'(g)))
        regs_flat[reg_base(g, DATA_W) +: DATA_W] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs_flat[reg_base(i, DATA_W) +: DATA_W];
  end

endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx
  import spi_rb_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 16,
  localparam int FRAME_BITS = frame_len(CMD_W, DATA_W),
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic              sclk,
  input  logic              frame_n,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              is_read,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              mode4,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sdo_o,
  output logic              sdo_oe,
  output logic              tail_low
);

  logic [DATA_W-1:0] txs;
  logic              bit_q;
  logic              drv_q;

  always_ff @(negedge sclk or posedge frame_n) begin
    if (frame_n) begin
      txs   <= '0;
      bit_q <= 1'b0;
      drv_q <= 1'b0;
    end else if (is_read && bit_cnt == CNT_W'(CMD_W)) begin
      txs   <= {rd_data[DATA_W-2:0], 1'b0};
      bit_q <= rd_data[DATA_W-1];
      drv_q <= 1'b1;
    end else if (drv_q && bit_cnt < CNT_W'(FRAME_BITS)) begin
      txs   <= {txs[DATA_W-2:0], 1'b0};
      bit_q <= txs[DATA_W-1];
    end else if (bit_cnt == CNT_W'(FRAME_BITS)) begin
      bit_q <= 1'b0;
    end
  end

  assign tail_low = drv_q && (bit_cnt == CNT_W'(FRAME_BITS));
  assign sdio_o   = bit_q;
  assign sdio_oe  = drv_q;
  assign sdo_o    = bit_q;
  assign sdo_oe   = drv_q && mode4;

endmodule

// File: rtl/spi_rb_slave.sv
module spi_rb_slave
  import spi_rb_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int DATA_W    = 16,
  parameter int CMD_W     = 8,
  parameter int CTRL_ADDR = 0,
  parameter int SRST_BIT  = 0,
  parameter int MODE_BIT  = 1,
  localparam int ADDR_W = CMD_W - 1,
  localparam int FRAME_BITS = frame_len(CMD_W, DATA_W),
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       frame_n,
  input  logic                       sdio_i,
  output logic                       sdio_o,
  output logic                       sdio_oe,
  output logic                       sdo_o,
  output logic                       sdo_oe,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] addr;
  logic              is_read;
  logic              wr_fire;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              soft_rst;
  logic              mode4;
  logic              tail_low;

  spi_rb_frame #(.CMD_W(CMD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
    .sclk(sclk), .frame_n(frame_n), .sdi(sdio_i), .bit_cnt(bit_cnt),
    .addr(addr), .is_read(is_read), .wr_fire(wr_fire), .wr_data(wr_data)
  );

  spi_rb_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                .CTRL_ADDR(CTRL_ADDR), .SRST_BIT(SRST_BIT)) u_bank (
    .sclk(sclk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(addr),
    .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data),
    .soft_rst(soft_rst), .regs_flat(regs_flat)
  );

  assign mode4 = regs_flat[reg_base(CTRL_ADDR, DATA_W) + MODE_BIT];

  spi_rb_tx #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_tx (
    .sclk(sclk), .frame_n(frame_n), .bit_cnt(bit_cnt), .is_read(is_read),
    .rd_data(rd_data), .mode4(mode4), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe), .tail_low(tail_low)
  );

endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker #(
  parameter int NUM_REGS = 128,
  parameter int DATA_W   = 16,
  parameter int CMD_W    = 8,
  parameter int ADDR_W   = 7,
  parameter int CNT_W    = 5
) (
  input logic                       sclk,
  input logic                       rst_n,
  input logic                       frame_n,
  input logic                       sdio_o,
  input logic                       sdio_oe,
  input logic                       sdo_o,
  input logic                       sdo_oe,
  input logic [CNT_W-1:0]           bit_cnt,
  input logic                       wr_fire,
  input logic                       soft_rst,
  input logic                       tail_low,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  function automatic logic [DATA_W-1:0] reg_at(input logic [ADDR_W-1:0] a);
    return regs_flat[int'(a) * DATA_W +: DATA_W];
  endfunction

  AST_WRITE_LANDS: assert property (@(posedge sclk) disable iff (!rst_n)
    (wr_fire && !soft_rst) |=> reg_at($past(addr)) == $past(wr_data)); // R3

  AST_SOFT_RESET_CLEARS: assert property (@(posedge sclk) disable iff (!rst_n)
    soft_rst |=> regs_flat == '0); // R9

  AST_NO_DRIVE_IDLE_CMD: assert property (@(posedge sclk) disable iff (!rst_n)
    (frame_n || bit_cnt < CNT_W'(CMD_W)) |-> (!sdio_oe && !sdo_oe)); // R8

  AST_DUAL_PIN_MATCH: assert property (@(posedge sclk) disable iff (!rst_n)
    sdo_oe |-> (sdio_oe && sdo_o == sdio_o)); // R6

  AST_TAIL_LOW: assert property (@(posedge sclk) disable iff (!rst_n)
    (tail_low && !frame_n) |-> (!sdio_o && !sdo_o)); // R7

endmodule

bind spi_rb_slave spi_rb_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .CMD_W(CMD_W),
  .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .sclk(sclk), .rst_n(rst_n), .frame_n(frame_n), .sdio_o(sdio_o),
  .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .bit_cnt(bit_cnt),
  .wr_fire(wr_fire), .soft_rst(soft_rst), .tail_low(tail_low), .addr(addr),
  .wr_data(wr_data), .regs_flat(regs_flat)
);

// File: tb/spi_rb_slave_bench.sv
`timescale 1ns/1ps
module spi_rb_slave_bench;

  localparam int NREG = 128;
  localparam int DW   = 16;

  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic frame_n = 1'b1;
  logic sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [NREG*DW-1:0] regs_flat;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [NREG];

  always #2.5 sclk = ~sclk;

  spi_rb_slave u_spi_rb_slave (
    .rst_n(rst_n), .sclk(sclk), .frame_n(frame_n), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .regs_flat(regs_flat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] bus_reg(input int a);
    return regs_flat[a*DW +: DW];
  endfunction

  function automatic bit model_4w();
    return model[0][1];
  endfunction

  // one frame of nbits; returns the words seen on both pins
  task automatic frame(input bit rd, input logic [6:0] a, input logic [15:0] d,
                       input int nbits, output logic [15:0] got_io,
                       output logic [15:0] got_so, output bit oe_bad_cmd,
                       output bit so_seen);
    logic [23:0] bits;
    bits = {rd, a, d};
    got_io = '0; got_so = '0; oe_bad_cmd = 0; so_seen = 0;
    @(negedge sclk); #1;
    frame_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (i > 0) begin @(negedge sclk); #1; end
      sdio_i = rd && i >= 8 ? 1'b0 : bits[23-i];
      if (i < 8 && (sdio_oe || sdo_oe)) oe_bad_cmd = 1;
      if (!rd && (sdio_oe || sdo_oe)) oe_bad_cmd = 1;
      if (i >= 8) begin
        got_io[23-i] = sdio_oe ? sdio_o : 1'bx;
        got_so[23-i] = sdo_o;
        if (sdo_oe) so_seen = 1;
      end
    end
  endtask

  task automatic end_frame();
    @(negedge sclk); #1;
    frame_n = 1'b1;
    #1;
    @(negedge sclk); #1;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d);
    logic [15:0] x, y; bit b, s;
    frame(1'b0, a, d, 24, x, y, b, s);
    end_frame();
    chk(!b, "R8 no drive in write frame", {31'd0, b}, 0);
    if (a == 0 && d[0]) for (int i = 0; i < NREG; i++) model[i] = '0;
    else model[a] = d;
  endtask

  // full read with tail and release checks
  task automatic do_read(input logic [6:0] a, input string tag);
    logic [15:0] io, so; bit b, s; bit w4;
    w4 = model_4w();
    frame(1'b1, a, 16'h0, 24, io, so, b, s);
    chk(!b, "R8 no drive during command", {31'd0, b}, 0);
    chk(io === model[a], {tag, " R1 R2 read data on sdio"}, {16'd0, io}, {16'd0, model[a]});
    if (w4) begin
      chk(s && so === model[a], "R6 read data on sdo in 4-wire", {16'd0, so}, {16'd0, model[a]});
    end else begin
      chk(!s, "R5 sdo never enabled in 3-wire", {31'd0, s}, 0);
    end
    @(negedge sclk); #1;
    chk(sdio_oe && sdio_o == 1'b0 && (!w4 || (sdo_oe && sdo_o == 1'b0)),
        "R7 tail held low while enabled", {28'd0, sdio_oe, sdio_o, sdo_oe, sdo_o}, {28'd0, 1'b1, 1'b0, w4, 1'b0});
    #2.5;
    chk(sdio_oe && sdio_o == 1'b0, "R7 tail still low before release", {30'd0, sdio_oe, sdio_o}, 2);
    frame_n = 1'b1;
    #0.5;
    chk(!sdio_oe && !sdo_oe, "R7 release on frame end", {30'd0, sdio_oe, sdo_oe}, 0);
    @(negedge sclk); #1;
  endtask

  task automatic t_reset();
    bit all0 = 1;
    for (int i = 0; i < NREG; i++) if (bus_reg(i) != 0) all0 = 0;
    chk(all0, "R10 bank zero in reset", {31'd0, all0}, 1);
    chk(!sdio_oe && !sdo_oe, "R10 no drive in reset", {30'd0, sdio_oe, sdo_oe}, 0);
  endtask

  task automatic t_basic_3w();
    do_write(7'd5, 16'hA5C3);
    chk(bus_reg(5) == 16'hA5C3, "R3 bus after write", {16'd0, bus_reg(5)}, 32'hA5C3);
    do_write(7'd127, 16'h8001);
    chk(bus_reg(127) == 16'h8001, "R3 top address", {16'd0, bus_reg(127)}, 32'h8001);
    do_write(7'd64, 16'hFFFF);
    do_write(7'd64, 16'h0F0F);
    chk(bus_reg(64) == 16'h0F0F, "R3 last write wins", {16'd0, bus_reg(64)}, 32'h0F0F);
    do_read(7'd5, "3w a5");
    do_read(7'd127, "3w a127");
    do_read(7'd64, "3w a64");
    do_read(7'd9, "3w zero reg");
  endtask

  task automatic t_short_write();
    logic [15:0] x, y; bit b, s;
    logic [15:0] before5;
    before5 = bus_reg(5);
    frame(1'b0, 7'd5, 16'h1234, 23, x, y, b, s);
    end_frame();
    chk(bus_reg(5) == before5, "R4 23-bit frame ignored", {16'd0, bus_reg(5)}, {16'd0, before5});
    frame(1'b0, 7'd0, 16'h0003, 12, x, y, b, s);
    end_frame();
    chk(bus_reg(0) == 16'h0 && bus_reg(5) == before5, "R4 short reset frame ignored",
        {16'd0, bus_reg(0)}, 0);
    do_read(7'd5, "R4 readback");
  endtask

  task automatic t_4w();
    do_write(7'd0, 16'h0002);
    chk(bus_reg(0) == 16'h0002, "R6 mode bit stored", {16'd0, bus_reg(0)}, 2);
    do_read(7'd5, "4w a5");
    do_write(7'd33, 16'h5AA5);
    do_read(7'd33, "4w a33");
    do_read(7'd0, "4w ctrl");
  endtask

  task automatic t_soft_reset();
    bit all0 = 1;
    do_write(7'd0, 16'h0003);
    for (int i = 0; i < NREG; i++) if (bus_reg(i) != 0) all0 = 0;
    chk(all0, "R9 bank cleared", {31'd0, all0}, 1);
    do_read(7'd0, "R9 ctrl reads zero");
    do_read(7'd5, "R9 3-wire again");
  endtask

  initial begin : watchdog
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge sclk);
    #1 t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge sclk);
    t_basic_3w();
    t_short_write();
    t_4w();
    t_soft_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule